// File: doc/BRIEF.md
# Indirect Branch Landing Tracker

This block holds the two control words that govern control-flow enforcement for a processor core: one copy for user privilege and one for supervisor privilege. It watches strobes from the instruction pipeline (tracked indirect branches, far transfers that always arm tracking, and decoded landing-marker instructions in their 32-bit and 64-bit forms), and for each one updates a small wait/suppress state held in the copy that the current privilege selects. From that state and the enable bits it derives the status lines the pipeline uses to decide whether the next instruction must be a landing marker.

When the pipeline finds a missing marker, it can ask the block to consult a legacy-code bitmap. The block forms a byte address from the control word and the linear instruction address. It issues a single read request with a valid/ready handshake, then accepts one returned byte. If the selected bit is set, the tracker is released: it is reset, and it is placed in the suppressed state unless suppression is disabled. If the bit is clear, a fault indication is returned. While a lookup is in flight, the block reports busy and ignores every other event. Fault delivery, decode and the memory itself sit outside the block.

The request channel follows normal valid/ready rules. Once `mem_req_valid` is high, it stays high with a stable address until `mem_req_ready` is seen high at a clock edge. The response is taken only in a cycle where `mem_rsp_ready` and `mem_rsp_valid` are both high. The block never drops a request it has raised.

Top module: `branch_landing_tracker`

## Requirements
- R1: After reset both control words read zero, `busy`, `mem_req_valid`, `lookup_done` and `wr_err` are low.
- R2: Pipeline events act on the user word when `cpl` is 3 and on the supervisor word for `cpl` 0, 1 or 2; a write goes to the user word when `wr_sel_user` is 1, otherwise to the supervisor word.
- R3: A write is rejected when any of data bits 6..9 is set, or when bits 2, 10 and 11 are all set; a rejected write leaves the word unchanged, `wr_invalid` is high in the same cycle as `wr_en`, and `wr_err` is high for exactly the following cycle.
- R4: For the word selected by `cpl`: `sstk_en` = bit 0, `sstk_wr_en` = bits 0 and 1, `mark_en` = bit 2, `mark_active` = bit 2 with bit 10 clear, `waiting` = bits 2 and 11; all five are low unless `glob_en` and `prot_mode` are both high.
- R5: A tracked indirect branch sets bit 11 when enables are on (R4 gate), bit 2 is set and bit 10 is clear; it has no effect when `ev_ds_pfx` is high and bit 4 is set.
- R6: A far transfer, with the R4 gate on and bit 2 set, sets bit 11 and clears bit 10 whatever bit 10 was.
- R7: `ev_mark32` acts only when `long_mode` is low and `ev_mark64` only when it is high; an acting marker clears bits 10 and 11 of the selected word.
- R8: At most one update per cycle, with priority write, then marker, then far transfer, then indirect branch.
- R9: A lookup started with bit 3 of the selected word clear raises no memory request; `lookup_done` and `lookup_fault` are both high in the next cycle.
- R10: With bit 3 set, the request address is {word[63:12], 12'h0} + (lin[47:0] >> 15), and the tested bit of the returned byte is lin[14:12].
- R11: On a set bitmap bit, bits 10 and 11 are cleared and bit 10 is then set unless bit 5 is set, with `lookup_fault` low; on a clear bit the word is unchanged and `lookup_fault` is high; either way `lookup_done` pulses for one cycle after the response.
- R12: From the start of a lookup until its response is taken, `busy` is high and writes, events and further lookup starts are ignored.
- R13: `mem_req_valid` holds with a stable address until taken; `mem_rsp_ready` is high only after the request is taken and until the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl | input | 2 | Current privilege level |
| glob_en | input | 1 | Global enforcement enable |
| prot_mode | input | 1 | Processor is in protected mode |
| long_mode | input | 1 | Processor is in 64-bit mode |
| ev_ind_br | input | 1 | Tracked indirect branch strobe |
| ev_ds_pfx | input | 1 | Branch carries the DS-override prefix |
| ev_far_xfer | input | 1 | Far transfer strobe |
| ev_mark32 | input | 1 | 32-bit landing marker decoded |
| ev_mark64 | input | 1 | 64-bit landing marker decoded |
| wr_en | input | 1 | Control word write strobe |
| wr_sel_user | input | 1 | Write targets the user word |
| wr_data | input | 64 | Write data |
| lookup_start | input | 1 | Start a legacy-bitmap lookup |
| lookup_lin_addr | input | 64 | Linear instruction address for the lookup |
| mem_req_valid | output | 1 | Bitmap byte read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Bitmap byte address |
| mem_rsp_valid | input | 1 | Returned byte valid |
| mem_rsp_ready | output | 1 | Block can accept the returned byte |
| mem_rsp_data | input | 8 | Returned bitmap byte |
| lookup_done | output | 1 | Lookup finished (one-cycle pulse) |
| lookup_fault | output | 1 | Lookup found no legacy permission |
| busy | output | 1 | Lookup outstanding; events ignored |
| user_ctl | output | 64 | User control word |
| sup_ctl | output | 64 | Supervisor control word |
| wr_invalid | output | 1 | Current write is rejected |
| wr_err | output | 1 | Pulse after a rejected write |
| sstk_en | output | 1 | Shadow stack enabled |
| sstk_wr_en | output | 1 | Shadow stack writes enabled |
| mark_en | output | 1 | Marker tracking enabled |
| mark_active | output | 1 | Tracking enabled and not suppressed |
| waiting | output | 1 | A landing marker is required next |

## Verification
The hardest situation to reach is an event that arrives while a lookup is stalled between request and response. In that case the ignored marker would otherwise have cleared the waiting bit that the bitmap hit is about to release. The stimulus first arms waiting with a far transfer. It then starts a lookup, keeps `mem_req_ready` low for a cycle and injects a marker. Only after that does it complete the handshake, so the final word shows both that the marker had no effect and that the hit applied its own update. The suppress-disable and miss variants repeat the same path with different control bits and returned bytes.

// File: rtl/blt_pkg.sv
package blt_pkg;
  localparam int CTL_W  = 64;
  localparam int NBANK  = 2;

  // Control word bit positions (decoded by the pipeline, so fixed)
  localparam int B_SSTK    = 0;
  localparam int B_SSTK_WR = 1;
  localparam int B_TRK     = 2;
  localparam int B_LEGACY  = 3;
  localparam int B_NOTRK   = 4;
  localparam int B_SUPDIS  = 5;
  localparam int B_RSV_LO  = 6;
  localparam int B_RSV_HI  = 9;
  localparam int B_SUPP    = 10;
  localparam int B_WAIT    = 11;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WRITE,
    OP_MARK,
    OP_FAR,
    OP_IND,
    OP_BM_HIT
  } op_e;

  typedef struct packed {
    op_e              op;
    logic             tgt_user;
    logic             gate;
    logic             ds_pfx;
    logic [CTL_W-1:0] wdata;
  } upd_s;

  function automatic logic ctl_invalid(input logic [CTL_W-1:0] v);
    return (|v[B_RSV_HI:B_RSV_LO]) || (v[B_TRK] && v[B_SUPP] && v[B_WAIT]);
  endfunction

  function automatic logic [CTL_W-1:0] ctl_next(input logic [CTL_W-1:0] cur,
                                                input upd_s u);
    logic [CTL_W-1:0] n;
    n = cur;
    case (u.op)
      OP_WRITE: if (!ctl_invalid(u.wdata)) n = u.wdata;
      OP_MARK: begin
        n[B_SUPP] = 1'b0;
        n[B_WAIT] = 1'b0;
      end
      OP_FAR: if (u.gate && cur[B_TRK]) begin
        n[B_WAIT] = 1'b1;
        n[B_SUPP] = 1'b0;
      end
      OP_IND: if (u.gate && cur[B_TRK] && !cur[B_SUPP] &&
                  !(u.ds_pfx && cur[B_NOTRK])) begin
        n[B_WAIT] = 1'b1;
      end
      OP_BM_HIT: begin
        n[B_WAIT] = 1'b0;
        n[B_SUPP] = !cur[B_SUPDIS];
      end
      default: n = cur;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/blt_event_arb.sv
module blt_event_arb
  import blt_pkg::*;
(
  input  logic [1:0]       cpl,
  input  logic             glob_en,
  input  logic             prot_mode,
  input  logic             long_mode,
  input  logic             busy,
  input  logic             ev_ind_br,
  input  logic             ev_ds_pfx,
  input  logic             ev_far_xfer,
  input  logic             ev_mark32,
  input  logic             ev_mark64,
  input  logic             wr_en,
  input  logic             wr_sel_user,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             bm_hit,
  input  logic             bm_hit_user,
  output upd_s             upd
);
  logic mark_act;
  logic cpl_user;

  assign mark_act = (ev_mark32 && !long_mode) || (ev_mark64 && long_mode);
  assign cpl_user = (cpl == 2'd3);

  always_comb begin
    upd.op       = OP_NONE;
    upd.tgt_user = cpl_user;
    upd.gate     = glob_en && prot_mode;
    upd.ds_pfx   = ev_ds_pfx;
    upd.wdata    = wr_data;
    if (bm_hit) begin
      upd.op       = OP_BM_HIT;
      upd.tgt_user = bm_hit_user;
    end else if (!busy) begin
      if (wr_en) begin
        upd.op       = OP_WRITE;
        upd.tgt_user = wr_sel_user;
      end else if (mark_act) begin
        upd.op = OP_MARK;
      end else if (ev_far_xfer) begin
        upd.op = OP_FAR;
      end else if (ev_ind_br) begin
        upd.op = OP_IND;
      end
    end
  end
endmodule

// File: rtl/blt_ctl_bank.sv
module blt_ctl_bank
  import blt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  upd_s             upd,
  output logic [CTL_W-1:0] user_q,
  output logic [CTL_W-1:0] sup_q,
  output logic             wr_invalid,
  output logic             wr_err
);
  logic [CTL_W-1:0] q [NBANK];
  logic             bad_wr;

  assign bad_wr     = (upd.op == OP_WRITE) && ctl_invalid(upd.wdata);
  assign wr_invalid = bad_wr;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam logic IS_USER = (i == 1) ? 1'b1 : 1'b0;
    logic hit;
    assign hit = (upd.op != OP_NONE) && (upd.tgt_user == IS_USER);

    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= '0;
      else if (hit) q[i] <= ctl_next(q[i], upd);
    end

    AST_BAD_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_wr && upd.tgt_user == IS_USER) |=> $stable(q[i])); // R3
    AST_MARK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (upd.op == OP_MARK && upd.tgt_user == IS_USER) |=> (!q[i][B_SUPP] && !q[i][B_WAIT])); // R7
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= bad_wr;
  end

  assign user_q = q[1];
  assign sup_q  = q[0];

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(bad_wr)); // R3
endmodule

// File: rtl/blt_lookup.sv
module blt_lookup
  import blt_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int LA_W    = 48,
  parameter int PAGE_SH = 12,
  parameter int BM_SH   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cpl_user,
  input  logic [CTL_W-1:0]  sel_ctl,
  input  logic [ADDR_W-1:0] lin_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [7:0]        mem_rsp_data,
  output logic              busy,
  output logic              bm_hit,
  output logic              bm_hit_user,
  output logic              done,
  output logic              fault
);
  localparam int IDX_W = 3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

  st_e               st;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              user_q;
  logic [ADDR_W-1:0] addr_c;
  logic              bit_sel;
  logic              unused_bits;

  assign addr_c = {sel_ctl[CTL_W-1:PAGE_SH], {PAGE_SH{1'b0}}}
                + ADDR_W'(lin_addr[LA_W-1:BM_SH]);
  assign unused_bits = ^{lin_addr[ADDR_W-1:LA_W], lin_addr[BM_SH-1-IDX_W+1+IDX_W-1:PAGE_SH+IDX_W],
                         lin_addr[PAGE_SH-1:0], sel_ctl[PAGE_SH-1:0]};
  assign bit_sel = mem_rsp_data[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      idx_q  <= '0;
      user_q <= 1'b0;
      done   <= 1'b0;
      fault  <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (sel_ctl[B_LEGACY]) begin
            st     <= S_REQ;
            addr_q <= addr_c;
            idx_q  <= lin_addr[PAGE_SH+IDX_W-1:PAGE_SH];
            user_q <= cpl_user;
          end else begin
            done  <= 1'b1;
            fault <= 1'b1;
          end
        end
        S_REQ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          st    <= S_IDLE;
          done  <= 1'b1;
          fault <= !bit_sel;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = (st == S_WAIT);
  assign bm_hit        = (st == S_WAIT) && mem_rsp_valid && bit_sel;
  assign bm_hit_user   = user_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R13
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rsp_ready) |-> $past(mem_req_valid && mem_req_ready)); // R13
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R12
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done); // R11
endmodule

// File: rtl/blt_status.sv
module blt_status
  import blt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic [CTL_W-1:0] ctl,
  output logic             sstk_en,
  output logic             sstk_wr_en,
  output logic             mark_en,
  output logic             mark_active,
  output logic             waiting
);
  logic unused_ctl;
  assign unused_ctl = ^{ctl[CTL_W-1:B_WAIT+1], ctl[B_RSV_HI:B_LEGACY]};

  assign sstk_en     = gate && ctl[B_SSTK];
  assign sstk_wr_en  = gate && ctl[B_SSTK] && ctl[B_SSTK_WR];
  assign mark_en     = gate && ctl[B_TRK];
  assign mark_active = gate && ctl[B_TRK] && !ctl[B_SUPP];
  assign waiting     = gate && ctl[B_TRK] && ctl[B_WAIT];

  AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> !(sstk_en || sstk_wr_en || mark_en || mark_active || waiting)); // R4
  AST_WR_NEEDS_SSTK: assert property (@(posedge clk) disable iff (!rst_n)
    sstk_wr_en |-> sstk_en); // R4
endmodule

// File: rtl/branch_landing_tracker.sv
module branch_landing_tracker
  import blt_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cpl,
  input  logic              glob_en,
  input  logic              prot_mode,
  input  logic              long_mode,
  input  logic              ev_ind_br,
  input  logic              ev_ds_pfx,
  input  logic              ev_far_xfer,
  input  logic              ev_mark32,
  input  logic              ev_mark64,
  input  logic              wr_en,
  input  logic              wr_sel_user,
  input  logic [63:0]       wr_data,
  input  logic              lookup_start,
  input  logic [ADDR_W-1:0] lookup_lin_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [7:0]        mem_rsp_data,
  output logic              lookup_done,
  output logic              lookup_fault,
  output logic              busy,
  output logic [63:0]       user_ctl,
  output logic [63:0]       sup_ctl,
  output logic              wr_invalid,
  output logic              wr_err,
  output logic              sstk_en,
  output logic              sstk_wr_en,
  output logic              mark_en,
  output logic              mark_active,
  output logic              waiting
);
  upd_s             upd;
  logic             bm_hit;
  logic             bm_hit_user;
  logic [CTL_W-1:0] sel_ctl;
  logic             cpl_user;

  assign cpl_user = (cpl == 2'd3);
  assign sel_ctl  = cpl_user ? user_ctl : sup_ctl;

  blt_event_arb u_arb (
    .cpl         (cpl),
    .glob_en     (glob_en),
    .prot_mode   (prot_mode),
    .long_mode   (long_mode),
    .busy        (busy),
    .ev_ind_br   (ev_ind_br),
    .ev_ds_pfx   (ev_ds_pfx),
    .ev_far_xfer (ev_far_xfer),
    .ev_mark32   (ev_mark32),
    .ev_mark64   (ev_mark64),
    .wr_en       (wr_en),
    .wr_sel_user (wr_sel_user),
    .wr_data     (wr_data),
    .bm_hit      (bm_hit),
    .bm_hit_user (bm_hit_user),
    .upd         (upd)
  );

  blt_ctl_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd        (upd),
    .user_q     (user_ctl),
    .sup_q      (sup_ctl),
    .wr_invalid (wr_invalid),
    .wr_err     (wr_err)
  );

  blt_lookup #(.ADDR_W(ADDR_W)) u_lookup (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (lookup_start),
    .cpl_user      (cpl_user),
    .sel_ctl       (sel_ctl),
    .lin_addr      (lookup_lin_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data),
    .busy          (busy),
    .bm_hit        (bm_hit),
    .bm_hit_user   (bm_hit_user),
    .done          (lookup_done),
    .fault         (lookup_fault)
  );

  blt_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate        (glob_en && prot_mode),
    .ctl         (sel_ctl),
    .sstk_en     (sstk_en),
    .sstk_wr_en  (sstk_wr_en),
    .mark_en     (mark_en),
    .mark_active (mark_active),
    .waiting     (waiting)
  );

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bm_hit) |=> ($stable(user_ctl) && $stable(sup_ctl))); // R12
  AST_ONE_WORD_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !(!$stable(user_ctl) && !$stable(sup_ctl))); // R8
endmodule

// File: tb/branch_landing_tracker_tb.sv
module branch_landing_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cpl = 2'd0;
  logic        glob_en = 1'b1, prot_mode = 1'b1, long_mode = 1'b0;
  logic        ev_ind_br = 0, ev_ds_pfx = 0, ev_far_xfer = 0, ev_mark32 = 0, ev_mark64 = 0;
  logic        wr_en = 0, wr_sel_user = 0;
  logic [63:0] wr_data = '0;
  logic        lookup_start = 0;
  logic [63:0] lookup_lin_addr = '0;
  logic        mem_req_valid, mem_req_ready = 0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 0, mem_rsp_ready;
  logic [7:0]  mem_rsp_data = '0;
  logic        lookup_done, lookup_fault, busy;
  logic [63:0] user_ctl, sup_ctl;
  logic        wr_invalid, wr_err;
  logic        sstk_en, sstk_wr_en, mark_en, mark_active, waiting;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  branch_landing_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cpl(cpl), .glob_en(glob_en), .prot_mode(prot_mode),
    .long_mode(long_mode), .ev_ind_br(ev_ind_br), .ev_ds_pfx(ev_ds_pfx),
    .ev_far_xfer(ev_far_xfer), .ev_mark32(ev_mark32), .ev_mark64(ev_mark64),
    .wr_en(wr_en), .wr_sel_user(wr_sel_user), .wr_data(wr_data),
    .lookup_start(lookup_start), .lookup_lin_addr(lookup_lin_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .lookup_done(lookup_done), .lookup_fault(lookup_fault), .busy(busy),
    .user_ctl(user_ctl), .sup_ctl(sup_ctl), .wr_invalid(wr_invalid), .wr_err(wr_err),
    .sstk_en(sstk_en), .sstk_wr_en(sstk_wr_en), .mark_en(mark_en),
    .mark_active(mark_active), .waiting(waiting)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic user, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel_user = user; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic do_ev(input logic ind, input logic ds, input logic far,
                       input logic m32, input logic m64);
    @(negedge clk);
    ev_ind_br = ind; ev_ds_pfx = ds; ev_far_xfer = far; ev_mark32 = m32; ev_mark64 = m64;
    @(posedge clk); #1;
    ev_ind_br = 0; ev_ds_pfx = 0; ev_far_xfer = 0; ev_mark32 = 0; ev_mark64 = 0;
  endtask

  task automatic t_reset;
    check("R1 user", user_ctl, 64'h0);
    check("R1 sup", sup_ctl, 64'h0);
    check("R1 idle", {busy, mem_req_valid, lookup_done, wr_err}, 4'h0);
  endtask

  task automatic t_status;
    cpl = 2'd3;
    do_write(1'b1, 64'h5);
    check("R2 user written", user_ctl, 64'h5);
    check("R2 sup untouched", sup_ctl, 64'h0);
    check("R4 status user", {sstk_en, sstk_wr_en, mark_en, mark_active, waiting}, 5'b10110);
    cpl = 2'd1; #1;
    check("R2 R4 sup selected", {sstk_en, mark_en}, 2'b00);
    cpl = 2'd3; glob_en = 0; #1;
    check("R4 gate glob", {sstk_en, sstk_wr_en, mark_en, mark_active, waiting}, 5'b0);
    glob_en = 1; prot_mode = 0; #1;
    check("R4 gate prot", {sstk_en, mark_en}, 2'b00);
    prot_mode = 1;
  endtask

  task automatic t_bad_write;
    @(negedge clk);
    wr_en = 1; wr_sel_user = 1; wr_data = 64'h40;
    #1 check("R3 invalid flag rsv", wr_invalid, 1);
    @(posedge clk); #1;
    wr_en = 0;
    check("R3 word kept", user_ctl, 64'h5);
    check("R3 err pulse", wr_err, 1);
    @(posedge clk); #1;
    check("R3 err single", wr_err, 0);
    do_write(1'b1, 64'hC04);
    check("R3 combo rejected", user_ctl, 64'h5);
    do_write(1'b1, 64'hC00);
    check("R3 combo without bit2 ok", user_ctl, 64'hC00);
  endtask

  task automatic t_indirect;
    cpl = 2'd3;
    do_write(1'b1, 64'h14);
    do_ev(1, 1, 0, 0, 0);
    check("R5 no-track exempt", user_ctl, 64'h14);
    do_ev(1, 0, 0, 0, 0);
    check("R5 tracked sets wait", user_ctl, 64'h814);
    check("R2 sup untouched", sup_ctl, 64'h0);
    check("R4 waiting", waiting, 1);
    do_write(1'b1, 64'h404);
    do_ev(1, 0, 0, 0, 0);
    check("R5 suppressed ignored", user_ctl, 64'h404);
    do_ev(0, 0, 1, 0, 0);
    check("R6 far arms", user_ctl, 64'h804);
    glob_en = 0;
    do_write(1'b1, 64'h4);
    do_ev(0, 0, 1, 0, 0);
    check("R6 far gated", user_ctl, 64'h4);
    glob_en = 1;
  endtask

  task automatic t_marker;
    cpl = 2'd3;
    do_write(1'b1, 64'h804);
    long_mode = 0;
    do_ev(0, 0, 0, 0, 1);
    check("R7 mark64 ignored outside long", user_ctl, 64'h804);
    do_ev(0, 0, 0, 1, 0);
    check("R7 mark32 clears", user_ctl, 64'h4);
    do_write(1'b1, 64'h804);
    long_mode = 1;
    do_ev(0, 0, 0, 1, 0);
    check("R7 mark32 ignored in long", user_ctl, 64'h804);
    do_ev(0, 0, 0, 0, 1);
    check("R7 mark64 clears", user_ctl, 64'h4);
    long_mode = 0;
  endtask

  task automatic t_priority;
    cpl = 2'd3;
    do_write(1'b1, 64'h804);
    do_ev(0, 0, 1, 1, 0);
    check("R8 marker over far", user_ctl, 64'h4);
    @(negedge clk);
    wr_en = 1; wr_sel_user = 1; wr_data = 64'h4; ev_ind_br = 1;
    @(posedge clk); #1;
    wr_en = 0; ev_ind_br = 0;
    check("R8 write over indirect", user_ctl, 64'h4);
  endtask

  task automatic t_no_legacy;
    cpl = 2'd0;
    do_write(1'b0, 64'h4);
    @(negedge clk);
    lookup_start = 1; lookup_lin_addr = 64'h1234_5000;
    @(posedge clk); #1;
    lookup_start = 0;
    check("R9 no request", mem_req_valid, 0);
    check("R9 done fault", {lookup_done, lookup_fault}, 2'b11);
    @(posedge clk); #1;
    check("R9 done single", lookup_done, 0);
  endtask

  task automatic run_lookup(input string tag, input logic [63:0] ctl,
                            input logic [63:0] lin, input logic [7:0] byte_v,
                            input logic exp_fault, input logic [63:0] exp_ctl);
    logic [63:0] exp_addr;
    cpl = 2'd0;
    do_write(1'b0, ctl);
    do_ev(0, 0, 1, 0, 0);
    exp_addr = {ctl[63:12], 12'h0} + (64'(lin[47:0]) >> 15);
    @(negedge clk);
    lookup_start = 1; lookup_lin_addr = lin;
    @(posedge clk); #1;
    lookup_start = 0;
    check({"R10 addr ", tag}, mem_req_addr, exp_addr);
    check({"R12 busy ", tag}, {busy, mem_req_valid}, 2'b11);
    do_ev(0, 0, 0, 1, 0);
    check({"R12 marker ignored ", tag}, sup_ctl, ctl | 64'h800);
    check({"R13 req held ", tag}, {mem_req_valid, mem_req_addr}, {1'b1, exp_addr});
    @(negedge clk);
    mem_req_ready = 1;
    @(posedge clk); #1;
    mem_req_ready = 0;
    check({"R13 handoff ", tag}, {mem_req_valid, mem_rsp_ready}, 2'b01);
    @(negedge clk);
    mem_rsp_valid = 1; mem_rsp_data = byte_v;
    @(posedge clk); #1;
    mem_rsp_valid = 0;
    check({"R11 done ", tag}, {lookup_done, lookup_fault, busy}, {1'b1, exp_fault, 1'b0});
    check({"R11 word ", tag}, sup_ctl, exp_ctl);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1;
    t_status();
    t_bad_write();
    t_indirect();
    t_marker();
    t_priority();
    t_no_legacy();
    // lin[14:12] = 5 -> bit 5 of the returned byte
    run_lookup("hit", 64'h0000_0000_ABCD_E00C, 64'h0000_0012_3456_D000, 8'h20, 1'b0,
               64'h0000_0000_ABCD_E40C);
    run_lookup("hit supdis", 64'h0000_0000_ABCD_E02C, 64'h0000_0012_3456_D000, 8'h20, 1'b0,
               64'h0000_0000_ABCD_E02C);
    run_lookup("miss", 64'h0000_0000_0010_000C, 64'hFFFF_0000_0000_2000, 8'hFB, 1'b1,
               64'h0000_0000_0010_080C);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule